// File: doc/BRIEF.md
# Zero-Start Pseudo-Noise Shift Generator

This block is a right-shifting Galois pseudo-noise generator with an inverted XOR condition. On each step the register moves one place toward bit 0. The tap constant is XORed into the shifted word only when the bit that left position 0 was a 0. A bit that leaves as a 1 passes the shifted word through unchanged. The result is an affine map instead of a linear one. The all-zero word becomes an ordinary member of the long cycle, so a plain synchronous clear is a valid seed.

For a maximal tap constant, the walk from zero covers 2^W-1 words before it comes back to zero. Exactly one nonzero word is excluded: the word that the map sends to itself. The block works out that word from the tap parameter at elaboration and raises `stuck` while the register holds it. Two inputs change the state directly. A `kick` forces the register back to zero. A `load` writes an arbitrary word, which is used to seed the register or to reach the lock-up word deliberately.

Each cycle one command is selected, in fixed priority order:
- CMD_CLEAR when `clr` is high.
- CMD_LOAD when `load` is high.
- CMD_KICK when `kick` is high.
- CMD_STEP when `en` is high.
- CMD_HOLD otherwise.

The command chooses the next state:
- CMD_CLEAR, CMD_LOAD and CMD_KICK write the state register and clear the serial bit.
- CMD_STEP advances the register.
- CMD_HOLD leaves everything as it is.

Any command can follow any other.

Top module: `pn_gen_cmp`

## Requirements
- R1: With `clr` high at a clock edge, after that edge `state_out` is 0 and `ser_out` is 0, whatever the other inputs are.
- R2: With `clr`, `load` and `kick` low and `en` high, the new state equals the old state shifted right by one (0 into bit W-1). If old bit 0 was 0, TAPS is then XORed in; if it was 1, nothing is XORed.
- R3: On a step, `ser_out` takes the value of state bit 0 from before that step.
- R4: With `clr`, `load`, `kick` and `en` all low, `state_out` and `ser_out` keep their values.
- R5: With `load` high and `clr` low, `state_out` becomes `load_val` and `ser_out` becomes 0. This applies even when `kick` or `en` is also high.
- R6: With `kick` high and `clr` and `load` low, `state_out` becomes 0 and `ser_out` becomes 0. This applies even when `en` is high.
- R7: Stepping from the all-zero state visits 2^W-1 distinct states before it returns to zero. With the defaults (W=8, TAPS=8'hB8) that is 255 states.
- R8: `stuck` is high exactly when `state_out` equals the fixed word. The fixed word has bit 0 equal to 0, and each bit k≥1 equal to the XOR of TAPS bits 0 to k-1. With the defaults the fixed word is 8'hD0.
- R9: While the register holds the fixed word, a step leaves it unchanged and `ser_out` reads 0.
- R10: The all-ones word is not the lock-up word: with the defaults, 8'hFF steps to 8'h7F with `ser_out` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| en | input | 1 | Advance one step |
| kick | input | 1 | Force the register to zero |
| load | input | 1 | Write `load_val` into the register |
| load_val | input | W | Word written by `load` |
| ser_out | output | 1 | Bit shifted out on the last step |
| state_out | output | W | Present register word |
| stuck | output | 1 | Register holds the self-mapping word |

## Verification
The checker covers the single-cycle rules on every clock edge:
- the outcome of each command and the command priority;
- the serial bit following the old bit 0;
- the stability of the register when idle;
- the lock-up word remaining fixed once reached.

Three properties concern whole orbits or the entire state space, so only the bench scenarios can show them:
- that the walk from zero really has length 2^W-1 and never repeats a word;
- that the lock-up word lies outside that walk;
- that the stuck flag marks one word and no other, which the bench checks by loading all 256 words.

// File: rtl/pn_cmp_pkg.sv
package pn_cmp_pkg;

    typedef enum logic [2:0] {
        CMD_HOLD  = 3'd0,
        CMD_STEP  = 3'd1,
        CMD_KICK  = 3'd2,
        CMD_LOAD  = 3'd3,
        CMD_CLEAR = 3'd4
    } pn_cmd_e;

endpackage

// File: rtl/pn_cmd_decode.sv
module pn_cmd_decode
    import pn_cmp_pkg::*;
(
    input  logic    clr,
    input  logic    en,
    input  logic    kick,
    input  logic    load,
    output pn_cmd_e cmd
);

    always_comb begin
        if (clr)       cmd = CMD_CLEAR;
        else if (load) cmd = CMD_LOAD;
        else if (kick) cmd = CMD_KICK;
        else if (en)   cmd = CMD_STEP;
        else           cmd = CMD_HOLD;
    end

endmodule

// File: rtl/pn_step.sv
module pn_step #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = 8'hB8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic inject;
    assign inject = ~cur[0];

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == W - 1) begin : g_top
            assign nxt[k] = TAPS[k] & inject;
        end else begin : g_low
            assign nxt[k] = cur[k+1] ^ (TAPS[k] & inject);
        end
    end

endmodule

// File: rtl/pn_fixpt_detect.sv
module pn_fixpt_detect #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = 8'hB8
) (
    input  logic [W-1:0] cur,
    output logic         hit
);

    function automatic logic [W-1:0] fixed_word();
        logic [W-1:0] x;
        x    = '0;
        x[0] = 1'b0;
        for (int k = 1; k < W; k++) x[k] = x[k-1] ^ TAPS[k-1];
        return x;
    endfunction

    localparam logic [W-1:0] FIX = fixed_word();

    assign hit = (cur == FIX);

endmodule

// File: rtl/pn_gen_cmp.sv
module pn_gen_cmp
    import pn_cmp_pkg::*;
#(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic         kick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         ser_out,
    output logic [W-1:0] state_out,
    output logic         stuck
);

    pn_cmd_e      cmd;
    logic [W-1:0] state_q;
    logic [W-1:0] step_val;
    logic         ser_q;

    pn_cmd_decode u_dec (
        .clr  (clr),
        .en   (en),
        .kick (kick),
        .load (load),
        .cmd  (cmd)
    );

    pn_step #(.W(W), .TAPS(TAPS)) u_step (
        .cur (state_q),
        .nxt (step_val)
    );

    pn_fixpt_detect #(.W(W), .TAPS(TAPS)) u_fix (
        .cur (state_q),
        .hit (stuck)
    );

    always_ff @(posedge clk) begin
        unique case (cmd)
            CMD_CLEAR: state_q <= '0;
            CMD_LOAD:  state_q <= load_val;
            CMD_KICK:  state_q <= '0;
            CMD_STEP:  state_q <= step_val;
            CMD_HOLD:  state_q <= state_q;
            default:   state_q <= '0;
        endcase
    end

    always_ff @(posedge clk) begin
        unique case (cmd)
            CMD_STEP: ser_q <= state_q[0];
            CMD_HOLD: ser_q <= ser_q;
            default:  ser_q <= 1'b0;
        endcase
    end

    assign state_out = state_q;
    assign ser_out   = ser_q;

endmodule

// File: rtl/pn_gen_cmp_chk.sv
module pn_gen_cmp_chk #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = 8'hB8
) (
    input logic         clk,
    input logic         clr,
    input logic         en,
    input logic         kick,
    input logic         load,
    input logic [W-1:0] load_val,
    input logic         ser_out,
    input logic [W-1:0] state_out,
    input logic         stuck
);

    logic do_step;
    logic idle;
    assign do_step = en & ~clr & ~load & ~kick;
    assign idle    = ~en & ~clr & ~load & ~kick;

    a_r1_clear: assert property (@(posedge clk) disable iff (clr)
        $past(clr) |-> (state_out == '0) && !ser_out);

    a_r2_step: assert property (@(posedge clk) disable iff (clr)
        do_step |=> state_out == (($past(state_out) >> 1) ^
                                  ($past(state_out[0]) ? '0 : TAPS)));

    a_r3_serial: assert property (@(posedge clk) disable iff (clr)
        do_step |=> ser_out == $past(state_out[0]));

    a_r4_hold: assert property (@(posedge clk) disable iff (clr)
        idle |=> $stable(state_out) && $stable(ser_out));

    a_r5_load: assert property (@(posedge clk) disable iff (clr)
        load |=> (state_out == $past(load_val)) && !ser_out);

    a_r6_kick: assert property (@(posedge clk) disable iff (clr)
        (kick && !load) |=> (state_out == '0) && !ser_out);

    a_r8_stuck_even: assert property (@(posedge clk) disable iff (clr)
        stuck |-> !state_out[0]);

    a_r9_fixed: assert property (@(posedge clk) disable iff (clr)
        (stuck && do_step) |=> stuck && $stable(state_out) && !ser_out);

endmodule

bind pn_gen_cmp pn_gen_cmp_chk #(.W(W), .TAPS(TAPS)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .en        (en),
    .kick      (kick),
    .load      (load),
    .load_val  (load_val),
    .ser_out   (ser_out),
    .state_out (state_out),
    .stuck     (stuck)
);

// File: tb/sim_pn_gen_cmp.sv
`timescale 1ns/1ps
module sim_pn_gen_cmp;

    localparam int         W    = 8;
    localparam logic [7:0] TAPS = 8'hB8;
    localparam int         NS   = 1 << W;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         en = 1'b0, kick = 1'b0, load = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         ser_out, stuck;
    logic [W-1:0] state_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pn_gen_cmp #(.W(W), .TAPS(TAPS)) u0 (
        .clk(clk), .clr(clr), .en(en), .kick(kick), .load(load),
        .load_val(load_val), .ser_out(ser_out), .state_out(state_out),
        .stuck(stuck)
    );

    function automatic logic [W-1:0] model_next(logic [W-1:0] s);
        return (s >> 1) ^ (s[0] ? 8'h00 : TAPS);
    endfunction

    function automatic logic [W-1:0] model_fix();
        logic [W-1:0] x = '0;
        for (int k = 1; k < W; k++) x[k] = x[k-1] ^ TAPS[k-1];
        return x;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic c, logic e, logic k, logic l, logic [W-1:0] v);
        clr = c; en = e; kick = k; load = l; load_val = v;
        @(posedge clk); #1;
        clr = 0; en = 0; kick = 0; load = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] fix;
        logic [W-1:0] prev;
        logic [NS-1:0] seen;
        int period;
        fix = model_fix();

        // R1: reset state
        drive(1, 0, 0, 0, '0);
        check("R1 state after clear", state_out, 0);
        check("R1 ser after clear", ser_out, 0);
        check("R8 stuck low at zero", stuck, 0);
        check("R8 fixed word formula", fix, 8'hD0);

        // R7/R2/R3/R8: walk from zero
        seen = '0;
        period = 0;
        do begin
            prev = state_out;
            seen[prev] = 1'b1;
            drive(0, 1, 0, 0, '0);
            period++;
            check("R2 step value", state_out, model_next(prev));
            check("R3 serial bit", ser_out, prev[0]);
            check("R8 stuck off in long cycle", stuck, 0);
            if (state_out != 0 && seen[state_out]) begin
                check("R7 repeat before zero", 1, 0);
                break;
            end
        end while (state_out != 0 && period < 2 * NS);
        check("R7 period from zero", period, NS - 1);
        check("R7 fixed word not visited", seen[fix], 0);

        // R8 sweep all words via load, R2 step from each
        for (int s = 0; s < NS; s++) begin
            drive(0, 0, 0, 1, s[W-1:0]);
            check("R5 load value", state_out, s);
            check("R8 stuck flag", stuck, (s[W-1:0] == fix) ? 1 : 0);
            drive(0, 1, 0, 0, '0);
            check("R2 step from loaded", state_out, model_next(s[W-1:0]));
        end

        // R9: lock-up word holds
        drive(0, 0, 0, 1, fix);
        for (int i = 0; i < 3; i++) begin
            drive(0, 1, 0, 0, '0);
            check("R9 fixed word holds", state_out, fix);
            check("R9 serial zero", ser_out, 0);
            check("R9 stuck stays high", stuck, 1);
        end

        // R10: all ones
        drive(0, 0, 0, 1, 8'hFF);
        drive(0, 1, 0, 0, '0);
        check("R10 all ones steps", state_out, 8'h7F);
        check("R10 serial one", ser_out, 1);

        // R4: hold
        prev = state_out;
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 0, 0, 8'h55);
            check("R4 hold state", state_out, prev);
            check("R4 hold ser", ser_out, 1);
        end

        // R6: kick beats step
        drive(0, 1, 1, 0, '0);
        check("R6 kick zero", state_out, 0);
        check("R6 kick ser", ser_out, 0);

        // R5: load beats kick and step
        drive(0, 1, 0, 0, '0);
        drive(0, 1, 1, 1, 8'h3C);
        check("R5 load priority", state_out, 8'h3C);
        check("R5 load ser", ser_out, 0);

        // R1: clear beats load
        drive(0, 1, 0, 0, '0);
        drive(1, 1, 1, 1, 8'hA5);
        check("R1 clear priority", state_out, 0);
        check("R1 clear ser", ser_out, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule